// File: doc/BRIEF.md
# Boundary Scan Data Register with Signature and Pattern Modes

This block is the boundary data register for a bus transceiver. Each I/O pin has exactly one scan cell. Input pins and output pins form one chain. The input cells hold the low bits, next to TDO, and the output cells hold the high bits, next to TDI. An external TAP controller supplies the strobes: capture, shift, update, run, a two-bit mode code and a test-mode flag. The TAP state machine and the instruction decoding are not part of this block. Every register changes on the rising edge of the test clock, except the TDO stage, which changes on the falling edge.

In normal mode the core's drive values go to the output pads, and the pad inputs go to the core. Capture, shift and update can run in normal mode without disturbing this flow, so the pins can be sampled while the device works. In test mode the update latches drive both boundaries.

With the run strobe, the register can also do three other jobs:
- It compresses the input pins into a signature.
- It generates pseudo-random patterns for the output pads.
- It splits itself: the input part compacts a signature while the output part counts in binary, for example to step through memory addresses.

Top module: `scan_boundary_reg`

## Requirements
- R1: After the asynchronous active-low reset, the shift register, the update latches and TDO are all zero.
- R2: While test_mode is 0, pad_out equals core_out and core_in equals pin_in, whatever the scan strobes do.
- R3: On a rising edge with capture_en high, bits [N_IN-1:0] of the shift register load pin_in and bits [W-1:N_IN] load the current pad_out. W is N_IN+N_OUT.
- R4: On a rising edge with shift_en high and capture_en low, the register shifts one place toward bit 0 and tdi enters bit W-1. tdo takes bit 0 on the following falling edge.
- R5: On a rising edge with update_en high, the update latches load the shift register's value from before that edge. This overrides any latch load by the run modes.
- R6: While test_mode is 1, pad_out equals update latch bits [W-1:N_IN] and core_in equals update latch bits [N_IN-1:0], whatever core_out and pin_in are.
- R7: Mode code 2'b01 with run_en is the signature mode, and it applies when capture_en and shift_en are low.
  - The register takes one Fibonacci LFSR step toward bit 0.
  - The feedback is the XOR of the tap bits and enters bit W-1.
  - pin_in is then XORed into bits [N_IN-1:0].
  - For W=16 the polynomial is x^16+x^14+x^13+x^11+1, so the feedback is bit 0 ^ bit 2 ^ bit 3 ^ bit 5.
- R8: Mode code 2'b10 with run_en is the pattern mode, and it applies when capture_en and shift_en are low. The register takes the same LFSR step with no input. The update latches load the new value, so the pads change every cycle in test mode.
- R9: Mode code 2'b11 with run_en is the split mode, and it applies when capture_en and shift_en are low.
  - Bits [N_IN-1:0] take an N_IN-bit LFSR step and pin_in is XORed in. For N_IN=8 the polynomial is x^8+x^6+x^5+x^4+1, so the feedback is bit 0 ^ bit 2 ^ bit 3 ^ bit 4.
  - Bits [W-1:N_IN] increment by one and wrap at all-ones.
  - The output-side update latches load the new count.
- R10: Mode code 2'b00 with run_en changes neither the shift register nor the update latches.
- R11: Capture has priority over shift, and shift has priority over any run mode, when they share an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| test_mode | input | 1 | 1 lets the update latches drive the boundary |
| capture_en | input | 1 | Load the pin states into the register |
| shift_en | input | 1 | Shift one bit from tdi toward tdo |
| update_en | input | 1 | Copy the register into the update latches |
| run_en | input | 1 | Advance the operation chosen by mode |
| mode | input | 2 | 00 sample, 01 signature, 10 pattern, 11 signature plus count |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| pin_in | input | N_IN | Input pad values |
| core_in | output | N_IN | Values presented to the core logic |
| core_out | input | N_OUT | Drive values from the core logic |
| pad_out | output | N_OUT | Values driven on the output pads |

## Verification
The bench goes after several corner cases:
- **Counter wrap.** The split-mode counter is seeded near all-ones so that it wraps. A counter that carried into the signature half would corrupt the low-byte signature, which is then shifted out and compared.
- **Cycle-by-cycle pattern output.** The pattern-mode pads are compared every cycle. A design that loaded the latches late, or not at all, would show a one-step lag.
- **Shared-edge strobes.** Capture, shift and run are raised on the same edge. A wrong priority would leave a stepped or shifted value in place of the captured one.
- **Boundary isolation.** Core and pad values change while test mode holds the boundary. A leaky multiplexer would pass them through.
- **Inert sample run.** The run strobe is pulsed in sample mode. A design that stepped the register there would corrupt the value shifted out afterwards.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    SBR_SAMPLE = 2'b00,
    SBR_PSA    = 2'b01,
    SBR_PRPG   = 2'b10,
    SBR_PSACNT = 2'b11
  } sbr_mode_e;

  // Fibonacci tap masks (bit k set => bit k feeds the XOR that enters the MSB)
  function automatic logic [31:0] tap_mask(input int unsigned width);
    logic [31:0] m;
    case (width)
      4:       m = 32'h0000_0003;
      6:       m = 32'h0000_0003;
      8:       m = 32'h0000_001D;
      10:      m = 32'h0000_0009;
      12:      m = 32'h0000_0107;
      16:      m = 32'h0000_002D;
      24:      m = 32'h0000_0087;
      32:      m = 32'hC000_0401;
      default: m = 32'h0000_0003;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sbr_reset_sync.sv
module sbr_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/sbr_next_state.sv
module sbr_next_state
  import sbr_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  localparam int W    = N_IN + N_OUT
) (
  input  logic [W-1:0]     sreg,
  input  logic [W-1:0]     upd,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             run_en,
  input  logic [1:0]       mode,
  input  logic             tdi,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] pad_obs,
  output logic [W-1:0]     sreg_nxt,
  output logic             sreg_we,
  output logic [W-1:0]     upd_nxt,
  output logic             upd_we
);
  localparam logic [31:0] TAPS_W = tap_mask(W);
  localparam logic [31:0] TAPS_I = tap_mask(N_IN);
  localparam logic [W-1:0]    MASK_W = TAPS_W[W-1:0];
  localparam logic [N_IN-1:0] MASK_I = TAPS_I[N_IN-1:0];
  localparam logic [N_OUT-1:0] ONE_O = N_OUT'(1);

  sbr_mode_e       mode_e;
  logic [W-1:0]    lfsr_full;
  logic [N_IN-1:0] lfsr_low;
  logic [N_OUT-1:0] cnt_nxt;
  logic            run_act;

  assign mode_e  = sbr_mode_e'(mode);
  assign run_act = run_en && !capture_en && !shift_en;

  always_comb begin
    lfsr_full = {^(sreg & MASK_W), sreg[W-1:1]};
    lfsr_low  = {^(sreg[N_IN-1:0] & MASK_I), sreg[N_IN-1:1]};
    cnt_nxt   = sreg[W-1:N_IN] + ONE_O;
  end

  always_comb begin
    sreg_nxt = sreg;
    sreg_we  = 1'b0;
    upd_nxt  = upd;
    upd_we   = 1'b0;
    if (capture_en) begin
      sreg_nxt = {pad_obs, pin_in};
      sreg_we  = 1'b1;
    end else if (shift_en) begin
      sreg_nxt = {tdi, sreg[W-1:1]};
      sreg_we  = 1'b1;
    end else if (run_act) begin
      case (mode_e)
        SBR_PSA: begin
          sreg_nxt = lfsr_full ^ {{N_OUT{1'b0}}, pin_in};
          sreg_we  = 1'b1;
        end
        SBR_PRPG: begin
          sreg_nxt = lfsr_full;
          sreg_we  = 1'b1;
          upd_nxt  = lfsr_full;
          upd_we   = 1'b1;
        end
        SBR_PSACNT: begin
          sreg_nxt = {cnt_nxt, lfsr_low ^ pin_in};
          sreg_we  = 1'b1;
          upd_nxt  = {cnt_nxt, upd[N_IN-1:0]};
          upd_we   = 1'b1;
        end
        default: ;
      endcase
    end
    if (update_en) begin
      upd_nxt = sreg;
      upd_we  = 1'b1;
    end
  end
endmodule

// File: rtl/sbr_state_regs.sv
module sbr_state_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sreg_nxt,
  input  logic         sreg_we,
  input  logic [W-1:0] upd_nxt,
  input  logic         upd_we,
  output logic [W-1:0] sreg,
  output logic [W-1:0] upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg <= '0;
    else if (sreg_we) sreg <= sreg_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd <= '0;
    else if (upd_we) upd <= upd_nxt;
  end
endmodule

// File: rtl/sbr_tdo_stage.sv
module sbr_tdo_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic lsb,
  output logic tdo
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tdo <= 1'b0;
    else        tdo <= lsb;
  end
endmodule

// File: rtl/sbr_pin_mux.sv
module sbr_pin_mux #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  localparam int W    = N_IN + N_OUT
) (
  input  logic             test_mode,
  input  logic [W-1:0]     upd,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pad_out
);
  for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
    assign core_in[i] = test_mode ? upd[i] : pin_in[i];
  end
  for (genvar j = 0; j < N_OUT; j++) begin : g_out_cell
    assign pad_out[j] = test_mode ? upd[N_IN+j] : core_out[j];
  end
endmodule

// File: rtl/scan_boundary_reg.sv
module scan_boundary_reg #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             test_mode,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             run_en,
  input  logic [1:0]       mode,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pad_out
);
  localparam int W = N_IN + N_OUT;
  localparam logic [N_OUT-1:0] ONE_O = N_OUT'(1);

  logic         rst_n;
  logic [W-1:0] sreg, upd, sreg_nxt, upd_nxt;
  logic         sreg_we, upd_we;

  sbr_reset_sync u_rst (.clk(tck), .arst_n(trst_n), .rst_n(rst_n));

  sbr_next_state #(.N_IN(N_IN), .N_OUT(N_OUT)) u_next (
    .sreg(sreg), .upd(upd), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .run_en(run_en), .mode(mode), .tdi(tdi),
    .pin_in(pin_in), .pad_obs(pad_out), .sreg_nxt(sreg_nxt),
    .sreg_we(sreg_we), .upd_nxt(upd_nxt), .upd_we(upd_we)
  );

  sbr_state_regs #(.W(W)) u_regs (
    .clk(tck), .rst_n(rst_n), .sreg_nxt(sreg_nxt), .sreg_we(sreg_we),
    .upd_nxt(upd_nxt), .upd_we(upd_we), .sreg(sreg), .upd(upd)
  );

  sbr_tdo_stage u_tdo (.clk(tck), .rst_n(rst_n), .lsb(sreg[0]), .tdo(tdo));

  sbr_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
    .test_mode(test_mode), .upd(upd), .pin_in(pin_in), .core_out(core_out),
    .core_in(core_in), .pad_out(pad_out)
  );

  // R4: serial output follows chain bit 0 from the last falling edge
  p_tdo_lsb_r4: assert property (@(posedge tck) disable iff (!rst_n)
    tdo == sreg[0]);

  // R4: shift moves every bit one place toward tdo
  p_shift_move_r4: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_en && !capture_en) |=> sreg[W-2:0] == $past(sreg[W-1:1]));

  // R3: capture loads pin values into the input cells
  p_capture_in_r3: assert property (@(posedge tck) disable iff (!rst_n)
    capture_en |=> sreg[N_IN-1:0] == $past(pin_in));

  // R5: update copies the chain into the latches
  p_update_copy_r5: assert property (@(posedge tck) disable iff (!rst_n)
    update_en |=> upd == $past(sreg));

  // R9: the output half counts by one in split mode
  p_count_step_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (run_en && mode == 2'b11 && !capture_en && !shift_en)
      |=> sreg[W-1:N_IN] == $past(sreg[W-1:N_IN]) + ONE_O);

  // R10: a sample-mode run leaves the state alone
  p_sample_idle_r10: assert property (@(posedge tck) disable iff (!rst_n)
    (run_en && mode == 2'b00 && !capture_en && !shift_en && !update_en)
      |=> ($stable(sreg) && $stable(upd)));
endmodule

// File: tb/scan_boundary_reg_test.sv
module scan_boundary_reg_test;
  logic       tck = 1'b0;
  logic       trst_n;
  logic       test_mode, capture_en, shift_en, update_en, run_en, tdi;
  logic [1:0] mode;
  logic [7:0] pin_in, core_out;
  logic [7:0] core_in, pad_out;
  logic       tdo;

  int checks = 0;
  int errors = 0;
  string req = "R1";

  logic [15:0] m_sreg, m_upd;
  logic        m_tdo;

  always #5 tck = ~tck;

  scan_boundary_reg uut (
    .tck(tck), .trst_n(trst_n), .test_mode(test_mode), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .run_en(run_en), .mode(mode),
    .tdi(tdi), .tdo(tdo), .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .pad_out(pad_out)
  );

  function automatic logic [7:0] exp_pad();
    return test_mode ? m_upd[15:8] : core_out;
  endfunction
  function automatic logic [7:0] exp_core();
    return test_mode ? m_upd[7:0] : pin_in;
  endfunction

  task automatic check(string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    check("tdo", {15'd0, tdo}, {15'd0, m_tdo});
    check("pad_out", {8'd0, pad_out}, {8'd0, exp_pad()});
    check("core_in", {8'd0, core_in}, {8'd0, exp_core()});
  endtask

  // Reference model: one rising edge, then the falling edge, then compare
  task automatic cyc();
    logic [15:0] s, u;
    int cnt;
    s = m_sreg;
    u = m_upd;
    if (capture_en) s = {exp_pad(), pin_in};
    else if (shift_en) s = {tdi, m_sreg[15:1]};
    else if (run_en) begin
      if (mode == 2'b01) begin
        s = {m_sreg[0] ^ m_sreg[2] ^ m_sreg[3] ^ m_sreg[5], m_sreg[15:1]};
        s[7:0] = s[7:0] ^ pin_in;
      end else if (mode == 2'b10) begin
        s = {m_sreg[0] ^ m_sreg[2] ^ m_sreg[3] ^ m_sreg[5], m_sreg[15:1]};
        u = s;
      end else if (mode == 2'b11) begin
        cnt = (int'(m_sreg[15:8]) + 1) % 256;
        s[15:8] = 8'(cnt);
        s[7:0] = {m_sreg[0] ^ m_sreg[2] ^ m_sreg[3] ^ m_sreg[4], m_sreg[7:1]} ^ pin_in;
        u[15:8] = s[15:8];
      end
    end
    if (update_en) u = m_sreg;
    @(posedge tck);
    m_sreg = s;
    m_upd  = u;
    @(negedge tck);
    m_tdo = m_sreg[0];
    #1;
    compare_all();
  endtask

  task automatic strobes(logic c, logic s, logic u, logic r, logic [1:0] m, logic d);
    capture_en = c; shift_en = s; update_en = u; run_en = r; mode = m; tdi = d;
  endtask

  task automatic shift_word(logic [15:0] v);
    for (int i = 0; i < 16; i++) begin
      strobes(0, 1, 0, 0, 2'b00, v[i]);
      cyc();
    end
    strobes(0, 0, 0, 0, 2'b00, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired during %s", req);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    trst_n = 1'b0;
    test_mode = 1'b1;
    strobes(0, 0, 0, 0, 2'b00, 0);
    pin_in = 8'h5A; core_out = 8'hC3;
    m_sreg = '0; m_upd = '0; m_tdo = 1'b0;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    // R1: latches and tdo are clear after reset
    for (int i = 0; i < 4; i++) cyc();
    shift_word(16'h0000);

    req = "R2";
    test_mode = 1'b0;
    for (int i = 0; i < 12; i++) begin
      pin_in = 8'($urandom); core_out = 8'($urandom);
      strobes(0, 1, i == 6, 0, 2'b00, 1'($urandom));
      cyc();
    end
    strobes(0, 0, 0, 0, 2'b00, 0);

    req = "R3";
    pin_in = 8'h3C; core_out = 8'hA5;
    strobes(1, 0, 0, 0, 2'b00, 0);
    cyc();
    req = "R4";
    shift_word(16'hBEEF);
    req = "R5";
    strobes(0, 0, 1, 0, 2'b00, 0);
    cyc();
    strobes(0, 0, 0, 0, 2'b00, 0);
    req = "R6";
    test_mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      pin_in = 8'($urandom); core_out = 8'($urandom);
      cyc();
    end
    // R3: capture in test mode observes the latched pad drive
    strobes(1, 0, 0, 0, 2'b00, 0);
    cyc();
    shift_word(16'h1234);

    req = "R7";
    for (int i = 0; i < 24; i++) begin
      pin_in = 8'($urandom);
      strobes(0, 0, 0, 1, 2'b01, 0);
      cyc();
    end
    shift_word(16'hACE1);

    req = "R8";
    for (int i = 0; i < 30; i++) begin
      strobes(0, 0, 0, 1, 2'b10, 0);
      cyc();
    end
    shift_word(16'hFD01);

    req = "R9";
    for (int i = 0; i < 20; i++) begin
      pin_in = 8'($urandom);
      strobes(0, 0, 0, 1, 2'b11, 0);
      cyc();
    end
    shift_word(16'h9C4B);

    req = "R10";
    for (int i = 0; i < 5; i++) begin
      pin_in = 8'($urandom);
      strobes(0, 0, 0, 1, 2'b00, 0);
      cyc();
    end
    strobes(0, 0, 1, 0, 2'b00, 0);
    cyc();
    shift_word(16'h0F0F);

    req = "R11";
    pin_in = 8'h81; core_out = 8'h7E;
    strobes(1, 1, 0, 1, 2'b01, 1);
    cyc();
    strobes(0, 1, 0, 1, 2'b10, 1);
    cyc();
    strobes(0, 1, 0, 1, 2'b11, 0);
    cyc();
    shift_word(16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule